// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits in the address stage of a 64-bit load/store pipeline. For each accepted request it forms the memory address from a base value and an immediate. Four addressing forms are supported: a signed byte offset with no scaling, an unsigned offset scaled by the access size, pre-indexed with base update, and post-indexed with base update. A base index of 31 selects the stack pointer instead of the general base operand. When the stack pointer is selected, its alignment is checked.

The unit produces a registered address together with a byte-lane enable mask for a 64-bit data bus. An access that runs past the end of an 8-byte lane group is issued as two beats on consecutive cycles. The unit also produces the updated base value for the indexed forms, and a fault pulse when the stack pointer is misaligned. A small combinational path zero-extends returned load data to 64 bits.

Top module: `ls_addr_unit`

## Requirements
- R1: With mode code 0 (unscaled), the address is base + sign-extended imm[8:0], with no shift. imm[11:9] is ignored, so any byte displacement from -256 to 255 is reachable.
- R2: With mode code 1 (scaled), the address is base + imm[11:0] × 4 when size64_i=0, or base + imm[11:0] × 8 when size64_i=1. The offset is never negative.
- R3: With mode codes 0 and 1, wb_valid_o stays 0.
- R4: With mode code 2 (pre-index), the address and wb_val_o both equal base + sign-extended imm[8:0]. wb_valid_o is 1 on the first beat.
- R5: With mode code 3 (post-index), the address is the unmodified base. wb_val_o is base + sign-extended imm[8:0], and wb_valid_o is 1 on the first beat.
- R6: When base_idx_i is 31, sp_val_i is used as the base and base_val_i is ignored.
- R7: When base_idx_i is 31 and sp_val_i[3:0] is not zero, fault_o is 1 for one cycle, one clock after acceptance. In that cycle out_valid_o and wb_valid_o are 0.
- R8: An access is 4 bytes when size64_i=0 and 8 bytes when size64_i=1. Let off be address[2:0]. On the first beat, be_o bit b is set exactly for off ≤ b < off+size, with b < 8.
- R9: If off+size > 8, split_o is 1 on both beats. Beat 0 (beat_o=0) carries the address and the upper lanes. On the next cycle, beat 1 (beat_o=1) carries the address rounded down to 8 plus 8, sets be_o bits b < off+size-8, and has wb_valid_o=0.
- R10: req_ready_o is 0 during the cycle of the first beat of a split access. A request presented then is ignored and produces no output.
- R11: All address and writeback arithmetic wraps modulo 2^64.
- R12: ld_data_o equals ld_data_i when ld_size64_i=1. Otherwise it equals the low 32 bits of ld_data_i with 32 zero bits above them.
- R13: After reset, out_valid_o, fault_o and wb_valid_o are 0 and req_ready_o is 1. An accepted request gives a one-cycle out_valid_o pulse on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit can accept a request |
| mode_i | input | 2 | Addressing form: 0 unscaled, 1 scaled, 2 pre-index, 3 post-index |
| size64_i | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| base_idx_i | input | 5 | Base register index; 31 selects the stack pointer |
| base_val_i | input | 64 | General base operand |
| sp_val_i | input | 64 | Stack pointer value |
| imm_i | input | 12 | Immediate field |
| out_valid_o | output | 1 | Address beat valid |
| addr_o | output | 64 | Beat address |
| be_o | output | 8 | Byte-lane enables |
| split_o | output | 1 | Access uses two beats |
| beat_o | output | 1 | Beat number (0 or 1) |
| wb_valid_o | output | 1 | Base update valid |
| wb_val_o | output | 64 | Updated base value |
| wb_idx_o | output | 5 | Register index for the update |
| fault_o | output | 1 | Stack pointer alignment fault |
| ld_size64_i | input | 1 | Width of returned load data |
| ld_data_i | input | 64 | Returned load data |
| ld_data_o | output | 64 | Zero-extended load data |

## Verification
The bench sweeps every mode and size against every low-address offset from 0 to 15. It uses a mid-range base and a base just below 2^64, and immediates at the signed extremes, at -1, and with the upper bits set. Each case is run through both the general operand and the stack pointer.

Each class of bug shows up as a specific symptom:
- A unit that shifts the unscaled immediate, or fails to mask imm[11:9], gives wrong addresses in mode 0.
- A unit that sign-extends the scaled immediate gives wrong addresses in mode 1.
- A unit that swaps the pre- and post-index rules issues the post-index access at the updated base.
- A unit that mis-sizes the lane mask, or the second beat, clips or duplicates lanes across an 8-byte boundary.
- A unit that accepts a request while busy emits a stray beat.
- A unit that ignores stack pointer misalignment issues the access instead of raising fault_o.

// File: rtl/ls_agu_pkg.sv
package ls_agu_pkg;

    localparam int XLEN       = 64;
    localparam int IMM_W      = 12;
    localparam int SIMM_W     = 9;
    localparam int IDX_W      = 5;
    localparam int LANES      = 8;
    localparam int SP_IDX     = 31;
    localparam int SP_ALIGN_W = 4;

    typedef enum logic [1:0] {
        AM_UNSCALED = 2'd0,
        AM_SCALED   = 2'd1,
        AM_PRE      = 2'd2,
        AM_POST     = 2'd3
    } am_e;

    typedef struct packed {
        logic [XLEN-1:0] addr;
        logic            wb_en;
        logic [XLEN-1:0] wb_val;
    } ea_t;

    typedef struct packed {
        logic [LANES-1:0] be_lo;
        logic [LANES-1:0] be_hi;
        logic             split;
    } lane_t;

    // Sign-extend the short signed field held in the low bits of the immediate
    function automatic logic [XLEN-1:0] sext_simm(input logic [IMM_W-1:0] imm);
        return {{(XLEN-SIMM_W){imm[SIMM_W-1]}}, imm[SIMM_W-1:0]};
    endfunction

    // Zero-extend the immediate and scale by the access size
    function automatic logic [XLEN-1:0] scaled_uimm(input logic [IMM_W-1:0] imm,
                                                    input logic sz64);
        logic [XLEN-1:0] z;
        z = {{(XLEN-IMM_W){1'b0}}, imm};
        return sz64 ? (z << $clog2(LANES)) : (z << $clog2(LANES/2));
    endfunction

endpackage

// File: rtl/ls_ea_calc.sv
module ls_ea_calc
    import ls_agu_pkg::*;
#(
    parameter int AW = XLEN,
    parameter int IW = IMM_W
) (
    input  am_e             mode,
    input  logic            sz64,
    input  logic [AW-1:0]   base,
    input  logic [IW-1:0]   imm,
    output ea_t             ea
);

    logic [AW-1:0] idx_sum;
    logic [AW-1:0] scl_sum;

    assign idx_sum = base + sext_simm(imm);
    assign scl_sum = base + scaled_uimm(imm, sz64);

    always_comb begin
        ea = '0;
        unique case (mode)
            AM_UNSCALED: begin
                ea.addr  = idx_sum;
                ea.wb_en = 1'b0;
            end
            AM_SCALED: begin
                ea.addr  = scl_sum;
                ea.wb_en = 1'b0;
            end
            AM_PRE: begin
                ea.addr   = idx_sum;
                ea.wb_en  = 1'b1;
                ea.wb_val = idx_sum;
            end
            AM_POST: begin
                ea.addr   = base;
                ea.wb_en  = 1'b1;
                ea.wb_val = idx_sum;
            end
            default: ea = '0;
        endcase
    end

endmodule

// File: rtl/ls_lane_mask.sv
module ls_lane_mask
    import ls_agu_pkg::*;
#(
    parameter int NL = LANES
) (
    input  logic [$clog2(NL)-1:0] off,
    input  logic                  sz64,
    output lane_t                 lm
);

    localparam int OW    = $clog2(NL);
    localparam int END_W = OW + 2;

    logic [END_W-1:0] nbytes;
    logic [END_W-1:0] end_pos;

    assign nbytes  = sz64 ? END_W'(NL) : END_W'(NL/2);
    assign end_pos = {2'b00, off} + nbytes;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        assign lm.be_lo[g] = (END_W'(g) >= {2'b00, off}) && (END_W'(g) < end_pos);
        assign lm.be_hi[g] = (END_W'(g + NL) < end_pos);
    end

    assign lm.split = (end_pos > END_W'(NL));

endmodule

// File: rtl/ls_ld_zext.sv
module ls_ld_zext
    import ls_agu_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  logic          sz64,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    localparam int HW = DW / 2;

    assign dout = sz64 ? din : {{(DW-HW){1'b0}}, din[HW-1:0]};

endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
    import ls_agu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  am_e              mode_i,
    input  logic             size64_i,
    input  logic [IDX_W-1:0] base_idx_i,
    input  logic [XLEN-1:0]  base_val_i,
    input  logic [XLEN-1:0]  sp_val_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic             out_valid_o,
    output logic [XLEN-1:0]  addr_o,
    output logic [LANES-1:0] be_o,
    output logic             split_o,
    output logic             beat_o,
    output logic             wb_valid_o,
    output logic [XLEN-1:0]  wb_val_o,
    output logic [IDX_W-1:0] wb_idx_o,
    output logic             fault_o,
    input  logic             ld_size64_i,
    input  logic [XLEN-1:0]  ld_data_i,
    output logic [XLEN-1:0]  ld_data_o
);

    localparam int LANE_W = $clog2(LANES);

    logic            use_sp;
    logic [XLEN-1:0] base_sel;
    logic            sp_misal;
    logic            accept;
    ea_t             ea;
    lane_t           lm;

    logic             busy_q;
    logic             out_valid_q;
    logic [XLEN-1:0]  addr_q;
    logic [LANES-1:0] be_q;
    logic [LANES-1:0] hi_be_q;
    logic             split_q;
    logic             beat_q;
    logic             wb_valid_q;
    logic [XLEN-1:0]  wb_val_q;
    logic [IDX_W-1:0] wb_idx_q;
    logic             fault_q;

    assign use_sp   = (base_idx_i == IDX_W'(SP_IDX));
    assign base_sel = use_sp ? sp_val_i : base_val_i;
    assign sp_misal = use_sp && (sp_val_i[SP_ALIGN_W-1:0] != '0);
    assign accept   = req_valid_i && !busy_q;

    ls_ea_calc #(.AW(XLEN), .IW(IMM_W)) ea_i (
        .mode (mode_i),
        .sz64 (size64_i),
        .base (base_sel),
        .imm  (imm_i),
        .ea   (ea)
    );

    ls_lane_mask #(.NL(LANES)) lane_i (
        .off  (ea.addr[LANE_W-1:0]),
        .sz64 (size64_i),
        .lm   (lm)
    );

    ls_ld_zext #(.DW(XLEN)) zext_i (
        .sz64 (ld_size64_i),
        .din  (ld_data_i),
        .dout (ld_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            out_valid_q <= 1'b0;
            addr_q      <= '0;
            be_q        <= '0;
            hi_be_q     <= '0;
            split_q     <= 1'b0;
            beat_q      <= 1'b0;
            wb_valid_q  <= 1'b0;
            wb_val_q    <= '0;
            wb_idx_q    <= '0;
            fault_q     <= 1'b0;
        end else if (accept) begin
            if (sp_misal) begin
                out_valid_q <= 1'b0;
                wb_valid_q  <= 1'b0;
                fault_q     <= 1'b1;
                busy_q      <= 1'b0;
            end else begin
                out_valid_q <= 1'b1;
                addr_q      <= ea.addr;
                be_q        <= lm.be_lo;
                hi_be_q     <= lm.be_hi;
                split_q     <= lm.split;
                beat_q      <= 1'b0;
                wb_valid_q  <= ea.wb_en;
                wb_val_q    <= ea.wb_val;
                wb_idx_q    <= base_idx_i;
                fault_q     <= 1'b0;
                busy_q      <= lm.split;
            end
        end else if (busy_q) begin
            out_valid_q <= 1'b1;
            addr_q      <= {addr_q[XLEN-1:LANE_W], {LANE_W{1'b0}}} + XLEN'(LANES);
            be_q        <= hi_be_q;
            beat_q      <= 1'b1;
            wb_valid_q  <= 1'b0;
            fault_q     <= 1'b0;
            busy_q      <= 1'b0;
        end else begin
            out_valid_q <= 1'b0;
            wb_valid_q  <= 1'b0;
            fault_q     <= 1'b0;
        end
    end

    assign req_ready_o = !busy_q;
    assign out_valid_o = out_valid_q;
    assign addr_o      = addr_q;
    assign be_o        = be_q;
    assign split_o     = split_q;
    assign beat_o      = beat_q;
    assign wb_valid_o  = wb_valid_q;
    assign wb_val_o    = wb_val_q;
    assign wb_idx_o    = wb_idx_q;
    assign fault_o     = fault_q;

endmodule

// File: rtl/ls_addr_unit_chk.sv
module ls_addr_unit_chk
    import ls_agu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid_i,
    input logic             req_ready_o,
    input am_e              mode_i,
    input logic             size64_i,
    input logic [IDX_W-1:0] base_idx_i,
    input logic [XLEN-1:0]  base_val_i,
    input logic             out_valid_o,
    input logic [XLEN-1:0]  addr_o,
    input logic [LANES-1:0] be_o,
    input logic             split_o,
    input logic             beat_o,
    input logic             wb_valid_o,
    input logic [XLEN-1:0]  wb_val_o,
    input logic             fault_o
);

    AST_NO_WB_OFFSET: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !beat_o && ($past(mode_i) == AM_UNSCALED || $past(mode_i) == AM_SCALED))
        |-> !wb_valid_o); // R3

    AST_PRE_SAME: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !beat_o && $past(mode_i) == AM_PRE) |-> (wb_valid_o && wb_val_o == addr_o)); // R4

    AST_POST_BASE: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !beat_o && $past(mode_i) == AM_POST && $past(base_idx_i) != IDX_W'(SP_IDX))
        |-> (addr_o == $past(base_val_i))); // R5

    AST_FAULT_SP: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> ($past(req_valid_i) && $past(base_idx_i) == IDX_W'(SP_IDX))); // R6

    AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> (!out_valid_o && !wb_valid_o)); // R7

    AST_BE_COUNT: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && !split_o)
        |-> ($countones(be_o) == ($past(size64_i) ? LANES : LANES/2))); // R8

    AST_SPLIT_SECOND: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && split_o && !beat_o) |=> (out_valid_o && beat_o && split_o && !wb_valid_o)); // R9

    AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
        (out_valid_o && split_o && !beat_o) |-> !req_ready_o); // R10

    AST_WB_FIRST: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> (out_valid_o && !beat_o)); // R13

endmodule

bind ls_addr_unit ls_addr_unit_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .mode_i      (mode_i),
    .size64_i    (size64_i),
    .base_idx_i  (base_idx_i),
    .base_val_i  (base_val_i),
    .out_valid_o (out_valid_o),
    .addr_o      (addr_o),
    .be_o        (be_o),
    .split_o     (split_o),
    .beat_o      (beat_o),
    .wb_valid_o  (wb_valid_o),
    .wb_val_o    (wb_val_o),
    .fault_o     (fault_o)
);

// File: tb/ls_addr_unit_tb_top.sv
`timescale 1ns/1ps
module ls_addr_unit_tb_top;
    import ls_agu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    am_e         mode_i = AM_UNSCALED;
    logic        size64_i = 1'b0;
    logic [4:0]  base_idx_i = '0;
    logic [63:0] base_val_i = '0;
    logic [63:0] sp_val_i = '0;
    logic [11:0] imm_i = '0;
    logic        out_valid_o;
    logic [63:0] addr_o;
    logic [7:0]  be_o;
    logic        split_o;
    logic        beat_o;
    logic        wb_valid_o;
    logic [63:0] wb_val_o;
    logic [4:0]  wb_idx_o;
    logic        fault_o;
    logic        ld_size64_i = 1'b0;
    logic [63:0] ld_data_i = '0;
    logic [63:0] ld_data_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    ls_addr_unit dut_i (
        .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .mode_i(mode_i), .size64_i(size64_i), .base_idx_i(base_idx_i),
        .base_val_i(base_val_i), .sp_val_i(sp_val_i), .imm_i(imm_i),
        .out_valid_o(out_valid_o), .addr_o(addr_o), .be_o(be_o), .split_o(split_o),
        .beat_o(beat_o), .wb_valid_o(wb_valid_o), .wb_val_o(wb_val_o),
        .wb_idx_o(wb_idx_o), .fault_o(fault_o), .ld_size64_i(ld_size64_i),
        .ld_data_i(ld_data_i), .ld_data_o(ld_data_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_req(input int m, input logic sz, input logic [4:0] idx,
                           input logic [63:0] bv, input logic [63:0] spv,
                           input logic [11:0] im);
        logic [63:0] sel, simm, uoff, ea, acc, wbv;
        logic [7:0]  elo, ehi;
        logic        flt, wbe, spl;
        int          n, off, endp;
        string       tag;
        sel  = (idx == 5'd31) ? spv : bv;
        flt  = (idx == 5'd31) && (sel[3:0] != 4'h0);
        simm = {{55{im[8]}}, im[8:0]};
        uoff = {52'b0, im} * (sz ? 64'd8 : 64'd4);
        ea   = (m == 1) ? sel + uoff : sel + simm;
        acc  = (m == 3) ? sel : ea;
        wbv  = sel + simm;
        wbe  = (m >= 2);
        n    = sz ? 8 : 4;
        off  = int'(acc[2:0]);
        endp = off + n;
        spl  = endp > 8;
        for (int b = 0; b < 8; b++) begin
            elo[b] = (b >= off) && (b < endp);
            ehi[b] = (b + 8) < endp;
        end
        case (m)
            0: tag = "R1";
            1: tag = "R2";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        if (idx == 5'd31) tag = {tag, " R6"};
        if (sel[63:12] == 52'hFFFFFFFFFFFFF) tag = {tag, " R11"};

        @(negedge clk);
        req_valid_i = 1'b1;
        mode_i      = am_e'(m);
        size64_i    = sz;
        base_idx_i  = idx;
        base_val_i  = bv;
        sp_val_i    = spv;
        imm_i       = im;
        @(negedge clk);
        req_valid_i = 1'b0;
        if (flt) begin
            chk("R7 fault", {63'b0, fault_o}, 64'd1);
            chk("R7 valid", {63'b0, out_valid_o}, 64'd0);
            chk("R7 wb", {63'b0, wb_valid_o}, 64'd0);
        end else begin
            chk("R13 valid", {63'b0, out_valid_o}, 64'd1);
            chk("R7 nofault", {63'b0, fault_o}, 64'd0);
            chk({tag, " addr"}, addr_o, acc);
            chk("R8 be", {56'b0, be_o}, {56'b0, elo});
            chk("R9 split", {63'b0, split_o}, {63'b0, spl});
            chk("R9 beat0", {63'b0, beat_o}, 64'd0);
            chk(wbe ? {tag, " wbv"} : "R3 nowb", {63'b0, wb_valid_o}, {63'b0, wbe});
            if (wbe) begin
                chk({tag, " wbval"}, wb_val_o, wbv);
                chk({tag, " wbidx"}, {59'b0, wb_idx_o}, {59'b0, idx});
            end
            chk("R10 ready", {63'b0, req_ready_o}, {63'b0, !spl});
            if (spl) begin
                // decoy request while busy; must be dropped
                req_valid_i = 1'b1;
                mode_i      = AM_UNSCALED;
                base_idx_i  = 5'd5;
                base_val_i  = 64'h1000;
                imm_i       = 12'h0;
                @(negedge clk);
                req_valid_i = 1'b0;
                chk("R9 valid1", {63'b0, out_valid_o}, 64'd1);
                chk("R9 beat1", {63'b0, beat_o}, 64'd1);
                chk("R9 addr1", addr_o, {acc[63:3], 3'b000} + 64'd8);
                chk("R9 be1", {56'b0, be_o}, {56'b0, ehi});
                chk("R9 wb1", {63'b0, wb_valid_o}, 64'd0);
                @(negedge clk);
                chk("R10 dropped", {63'b0, out_valid_o}, 64'd0);
            end
        end
    endtask

    logic [11:0] imms [8];
    logic [63:0] bases [2];

    initial begin
        imms[0] = 12'h000; imms[1] = 12'h001; imms[2] = 12'h0FF; imms[3] = 12'h100;
        imms[4] = 12'h1FF; imms[5] = 12'hE05; imms[6] = 12'hFFF; imms[7] = 12'h003;
        bases[0] = 64'h0000_1234_5678_9A00;
        bases[1] = 64'hFFFF_FFFF_FFFF_FF00;

        repeat (3) @(negedge clk);
        chk("R13 rst valid", {63'b0, out_valid_o}, 64'd0);
        chk("R13 rst ready", {63'b0, req_ready_o}, 64'd1);
        chk("R13 rst fault", {63'b0, fault_o}, 64'd0);
        chk("R13 rst wb", {63'b0, wb_valid_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R13 idle", {63'b0, out_valid_o}, 64'd0);

        for (int m = 0; m < 4; m++)
            for (int s = 0; s < 2; s++)
                for (int bi = 0; bi < 2; bi++)
                    for (int lo = 0; lo < 16; lo++)
                        for (int ii = 0; ii < 8; ii++) begin
                            run_req(m, s[0], 5'd7, bases[bi] + 64'(lo),
                                    64'hDEAD_BEEF_0000_0000, imms[ii]);
                            run_req(m, s[0], 5'd31, 64'hDEAD_BEEF_0000_0000,
                                    bases[bi] + 64'(lo), imms[ii]);
                        end

        // zero extension of returned data
        for (int k = 0; k < 4; k++) begin
            ld_data_i   = 64'hF0E1_D2C3_B4A5_9687 ^ {32'(k), 32'(k * 7)};
            ld_size64_i = 1'b0;
            #1;
            chk("R12 narrow", ld_data_o, {32'b0, ld_data_i[31:0]});
            ld_size64_i = 1'b1;
            #1;
            chk("R12 wide", ld_data_o, ld_data_i);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule